// File: doc/BRIEF.md
# Monochrome to Colour Expander

The block turns a packed one-bit-per-pixel bitmap into colour pixels for a 2D drawing engine. The host pushes 32-bit source words through a valid/ready input. Each bit picks one of two 32-bit colour values: a one selects the foreground and a zero selects the background. Pixels leave on a valid/ready output at a destination depth of 8, 16 or 32 bits per pixel. At the narrower depths the pixel is carried in the low bits of the 32-bit output.

A pulse on `start_i` loads the rectangle size, the per-row bit skip, the depth code and both colours, and then starts a frame. Every row begins on a new source word. The block counts columns and rows, so it can flag the last pixel of each row and the last pixel of the frame. Once the final pixel has been taken downstream it raises a done flag, and that flag stays up until the next start.

Top module: `mono_expand`

## Requirements
- R1: After reset, `src_ready_o`, `pix_valid_o` and `done_o` are 0. While no frame is running, `src_ready_o` stays 0 even if `src_valid_i` is high.
- R2: A `start_i` pulse while no frame is running loads all configuration inputs, and the block asks for a source word on the next cycle. A `start_i` pulse during a frame has no effect on the pixels produced.
- R3: Pixel x of a row uses row bit index p = skip + x. That bit lies in word number p/32 of the row, at bit position 31 − (p mod 32). Bits are therefore used from the most significant bit downward.
- R4: A source bit of 1 outputs the foreground colour and a bit of 0 outputs the background colour.
- R5: Depth code 0 gives 8 bpp, with bits 31:8 of the pixel forced to 0. Code 1 gives 16 bpp, with bits 31:16 forced to 0. Code 3 gives 32 bpp, with all bits passed. Code 2 behaves as 32 bpp.
- R6: A frame holds (height_m1+1) rows of (width_m1+1) pixels. Each row uses exactly ((skip+width_m1)>>5)+1 source words, and the unused trailing bits of the last word are dropped.
- R7: `row_end_o` is high together with the last pixel of every row. `frame_end_o` is high only with the last pixel of the last row.
- R8: Skip values up to 32767 (15 bits) are supported. Width and height are 12-bit minus-one values.
- R9: `done_o` rises in the cycle after the last pixel is accepted. It stays high until the next start and is 0 once a start has been taken.
- R10: While `pix_valid_o` is high and `pix_ready_i` is low, the pixel is held unchanged. `src_ready_o` and `pix_valid_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load configuration and begin a frame |
| width_m1_i | input | 12 | Rectangle width minus one |
| height_m1_i | input | 12 | Rectangle height minus one |
| skip_i | input | 15 | Leading source bits skipped on each row |
| depth_i | input | 2 | Depth code: 0=8, 1=16, 3=32 bpp |
| fg_i | input | 32 | Foreground colour |
| bg_i | input | 32 | Background colour |
| src_valid_i | input | 1 | Source word valid |
| src_data_i | input | 32 | Source bitmap word |
| src_ready_o | output | 1 | Source word accepted |
| pix_valid_o | output | 1 | Pixel valid |
| pix_data_o | output | 32 | Pixel colour, zero-extended at 8/16 bpp |
| pix_ready_i | input | 1 | Downstream accepts pixel |
| row_end_o | output | 1 | Current pixel is the last of its row |
| frame_end_o | output | 1 | Current pixel is the last of the frame |
| done_o | output | 1 | Frame complete |

## Verification
A source word accepted at a clock edge appears as a pixel at the next cycle's output, because only the word register lies between the two. A pixel, together with its row and frame flags, stays on the output until the edge at which it is accepted. `done_o` follows one register stage after the final pixel handshake. The bench drives inputs on the falling edge and reads the outputs 1 ns later, before the next rising edge. It counts its own handshakes in that window and works out every expected pixel from the row, the column, the skip and the word pattern. After the last handshake it checks `done_o` at the following falling edge.

// File: rtl/mx_pkg.sv
package mx_pkg;
  localparam logic [1:0] DEPTH_8  = 2'd0;
  localparam logic [1:0] DEPTH_16 = 2'd1;
  localparam int unsigned COLOR_W = 32;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} mx_state_e;

  function automatic logic [COLOR_W-1:0] depth_mask(input logic [1:0] d);
    case (d)
      DEPTH_8:  return COLOR_W'(32'h0000_00FF);
      DEPTH_16: return COLOR_W'(32'h0000_FFFF);
      default:  return '1;
    endcase
  endfunction
endpackage

// File: rtl/mx_ctrl.sv
module mx_ctrl
  import mx_pkg::*;
#(
  parameter int unsigned COORD_W = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [COORD_W-1:0] w_m1_i,
  input  logic [COORD_W-1:0] h_m1_i,
  input  logic               fire_i,
  output logic               launch_o,
  output logic               run_o,
  output logic               done_o,
  output logic [COORD_W-1:0] col_o,
  output logic               last_col_o,
  output logic               last_row_o
);
  mx_state_e           state_q;
  logic [COORD_W-1:0]  col_q, row_q;

  assign launch_o   = start_i && (state_q != ST_RUN);
  assign run_o      = (state_q == ST_RUN);
  assign done_o     = (state_q == ST_DONE);
  assign col_o      = col_q;
  assign last_col_o = (col_q == w_m1_i);
  assign last_row_o = (row_q == h_m1_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      col_q   <= '0;
      row_q   <= '0;
    end else if (launch_o) begin
      state_q <= ST_RUN;
      col_q   <= '0;
      row_q   <= '0;
    end else if (run_o && fire_i) begin
      if (last_col_o) begin
        col_q <= '0;
        if (last_row_o) state_q <= ST_DONE;
        else            row_q   <= row_q + 1'b1;
      end else begin
        col_q <= col_q + 1'b1;
      end
    end
  end

  // R6
  col_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_o |-> (col_q <= w_m1_i));
  // R6
  row_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_o |-> (row_q <= h_m1_i));
  // R9
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o);
endmodule

// File: rtl/mx_wordbuf.sv
module mx_wordbuf #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned IDX_W  = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              en_i,
  input  logic [IDX_W-1:0]  need_idx_i,
  input  logic              src_valid_i,
  input  logic [WORD_W-1:0] src_data_i,
  output logic              src_ready_o,
  output logic              hit_o,
  output logic [WORD_W-1:0] word_o
);
  logic              have_q;
  logic [IDX_W-1:0]  idx_q, nxt_q;
  logic [WORD_W-1:0] word_q;

  assign hit_o       = have_q && (idx_q == need_idx_i);
  assign src_ready_o = en_i && !hit_o;
  assign word_o      = word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_q <= 1'b0;
      idx_q  <= '0;
      nxt_q  <= '0;
      word_q <= '0;
    end else if (clear_i) begin
      have_q <= 1'b0;
      nxt_q  <= '0;
    end else if (src_valid_i && src_ready_o) begin
      word_q <= src_data_i;
      idx_q  <= nxt_q;
      nxt_q  <= nxt_q + 1'b1;
      have_q <= 1'b1;
    end
  end

  // R6: words of a row are taken in order, never ahead of the pixel needing them
  fetch_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && have_q) |-> (idx_q <= need_idx_i));
endmodule

// File: rtl/mx_colour.sv
module mx_colour
  import mx_pkg::*;
(
  input  logic               bit_i,
  input  logic [1:0]         depth_i,
  input  logic [COLOR_W-1:0] fg_i,
  input  logic [COLOR_W-1:0] bg_i,
  output logic [COLOR_W-1:0] pix_o
);
  assign pix_o = (bit_i ? fg_i : bg_i) & depth_mask(depth_i);
endmodule

// File: rtl/mono_expand.sv
module mono_expand
  import mx_pkg::*;
#(
  parameter int unsigned COORD_W = 12,
  parameter int unsigned SKIP_W  = 15,
  parameter int unsigned WORD_W  = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [COORD_W-1:0] width_m1_i,
  input  logic [COORD_W-1:0] height_m1_i,
  input  logic [SKIP_W-1:0]  skip_i,
  input  logic [1:0]         depth_i,
  input  logic [31:0]        fg_i,
  input  logic [31:0]        bg_i,
  input  logic               src_valid_i,
  input  logic [WORD_W-1:0]  src_data_i,
  output logic               src_ready_o,
  output logic               pix_valid_o,
  output logic [31:0]        pix_data_o,
  input  logic               pix_ready_i,
  output logic               row_end_o,
  output logic               frame_end_o,
  output logic               done_o
);
  localparam int unsigned POS_W = ((SKIP_W > COORD_W) ? SKIP_W : COORD_W) + 1;
  localparam int unsigned LOG_W = $clog2(WORD_W);
  localparam int unsigned IDX_W = POS_W - LOG_W;

  logic [COORD_W-1:0] w_m1_q, h_m1_q, col;
  logic [SKIP_W-1:0]  skip_q;
  logic [1:0]         depth_q;
  logic [31:0]        fg_q, bg_q;
  logic               launch, run, fire, last_col, last_row, hit;
  logic [POS_W-1:0]   pos;
  logic [WORD_W-1:0]  word;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      w_m1_q  <= '0;
      h_m1_q  <= '0;
      skip_q  <= '0;
      depth_q <= '0;
      fg_q    <= '0;
      bg_q    <= '0;
    end else if (launch) begin
      w_m1_q  <= width_m1_i;
      h_m1_q  <= height_m1_i;
      skip_q  <= skip_i;
      depth_q <= depth_i;
      fg_q    <= fg_i;
      bg_q    <= bg_i;
    end
  end

  mx_ctrl #(.COORD_W(COORD_W)) ctrl_i (
    .clk_i, .rst_ni, .start_i,
    .w_m1_i(w_m1_q), .h_m1_i(h_m1_q), .fire_i(fire),
    .launch_o(launch), .run_o(run), .done_o(done_o), .col_o(col),
    .last_col_o(last_col), .last_row_o(last_row)
  );

  assign pos = POS_W'(skip_q) + POS_W'(col);

  mx_wordbuf #(.WORD_W(WORD_W), .IDX_W(IDX_W)) wbuf_i (
    .clk_i, .rst_ni,
    .clear_i(launch || (fire && last_col)), .en_i(run),
    .need_idx_i(pos[POS_W-1:LOG_W]),
    .src_valid_i, .src_data_i, .src_ready_o,
    .hit_o(hit), .word_o(word)
  );

  mx_colour colour_i (
    .bit_i(word[~pos[LOG_W-1:0]]), .depth_i(depth_q),
    .fg_i(fg_q), .bg_i(bg_q), .pix_o(pix_data_o)
  );

  assign pix_valid_o = run && hit;
  assign fire        = pix_valid_o && pix_ready_i;
  assign row_end_o   = pix_valid_o && last_col;
  assign frame_end_o = row_end_o && last_row;

  // R10
  pix_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_o && !pix_ready_i) |=> (pix_valid_o && $stable(pix_data_o) && $stable(row_end_o)));
  // R10
  side_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(src_ready_o && pix_valid_o));
  // R7
  frame_row_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_o |-> row_end_o);
  // R9
  done_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(frame_end_o && pix_ready_i));
  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |-> (!src_ready_o && !pix_valid_o));
endmodule

// File: tb/mono_expand_tb_top.sv
`timescale 1ns/1ps
module mono_expand_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [11:0] width_m1_i = '0, height_m1_i = '0;
  logic [14:0] skip_i = '0;
  logic [1:0]  depth_i = '0;
  logic [31:0] fg_i = '0, bg_i = '0;
  logic        src_valid_i = 1'b0;
  logic [31:0] src_data_i = '0;
  logic        src_ready_o, pix_valid_o, pix_ready_i, row_end_o, frame_end_o, done_o;
  logic [31:0] pix_data_o;
  int n_cmp = 0, n_bad = 0;

  always #2 clk = ~clk;

  mono_expand dut_i (
    .clk_i(clk), .rst_ni, .start_i, .width_m1_i, .height_m1_i, .skip_i,
    .depth_i, .fg_i, .bg_i, .src_valid_i, .src_data_i, .src_ready_o,
    .pix_valid_o, .pix_data_o, .pix_ready_i, .row_end_o, .frame_end_o, .done_o
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] pat(input int s, input int r, input int k);
    logic [31:0] v;
    v = 32'(s * 7919 + r * 104729 + k * 31337 + 12345);
    v = v * 32'h9E37_79B1;
    v = v ^ (v >> 15);
    return v;
  endfunction

  function automatic logic [31:0] msk(input int d);
    if (d == 0) return 32'h0000_00FF;
    if (d == 1) return 32'h0000_FFFF;
    return 32'hFFFF_FFFF;
  endfunction

  task automatic run_frame(input int wm, input int hm, input int sk, input int dp,
                           input int seed, input bit mid, input string tag);
    int pr, pk, cx, cr, nw, t, p;
    bit fin, stall, eb;
    logic [31:0] held, w, fg, bg, ex;
    fg = pat(seed, 999, 1);
    bg = ~fg;
    nw = ((sk + wm) >> 5) + 1;
    @(negedge clk);
    width_m1_i = 12'(wm); height_m1_i = 12'(hm); skip_i = 15'(sk);
    depth_i = 2'(dp); fg_i = fg; bg_i = bg;
    start_i = 1'b1; src_valid_i = 1'b0; pix_ready_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    #1;
    chk(done_o == 1'b0, "R9 done cleared by start", {31'd0, done_o}, 0);
    chk(src_ready_o == 1'b1, "R2 start requests word", {31'd0, src_ready_o}, 1);
    pr = 0; pk = 0; cx = 0; cr = 0; fin = 0; stall = 0; t = 0; held = '0;
    @(negedge clk);
    while (!fin && t < 20000) begin
      src_valid_i = (pr <= hm) && (t % 5 != 3);
      src_data_i  = pat(seed, pr, pk);
      pix_ready_i = (t % 7 != 2);
      if (mid && t == 6) begin
        // R2: restart attempt mid-frame with a different shape
        start_i = 1'b1; width_m1_i = 12'(wm + 5); skip_i = 15'(sk + 3);
        depth_i = 2'd3; fg_i = ~fg;
      end else start_i = 1'b0;
      #1;
      if (stall)
        chk(pix_valid_o && pix_data_o == held, "R10 held pixel", pix_data_o, held);
      if (src_ready_o && pix_valid_o)
        chk(1'b0, "R10 both sides active", 1, 0);
      if (src_valid_i && src_ready_o) begin
        pk++;
        if (pk == nw) begin pk = 0; pr++; end
      end
      if (pix_valid_o && pix_ready_i) begin
        p  = sk + cx;
        w  = pat(seed, cr, p >> 5);
        eb = w[31 - (p & 31)];
        ex = (eb ? fg : bg) & msk(dp);
        chk(pix_data_o == ex, {tag, " pixel colour"}, pix_data_o, ex);
        chk(row_end_o == (cx == wm) && frame_end_o == (cx == wm && cr == hm),
            "R7 row/frame flags", {30'd0, row_end_o, frame_end_o},
            {30'd0, 1'(cx == wm), 1'(cx == wm && cr == hm)});
        if (cx == wm) begin
          cx = 0;
          if (cr == hm) fin = 1; else cr++;
        end else cx++;
      end
      stall = pix_valid_o && !pix_ready_i;
      held  = pix_data_o;
      t++;
      @(negedge clk);
    end
    if (!fin) chk(1'b0, "R6 frame watchdog", 32'(t), 0);
    start_i = 1'b0; src_valid_i = 1'b0; pix_ready_i = 1'b0;
    #1;
    chk(done_o == 1'b1, "R9 done after last pixel", {31'd0, done_o}, 1);
    chk(pix_valid_o == 1'b0 && src_ready_o == 1'b0, "R1 quiet after frame",
        {30'd0, pix_valid_o, src_ready_o}, 0);
    chk(pr == hm + 1 && pk == 0, "R6 words per row", 32'(pr * 65536 + pk), 32'((hm + 1) * 65536));
  endtask

  initial begin
    #(4 * 190000);
    chk(1'b0, "global watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int deps[3]   = '{0, 1, 3};
    int widths[3] = '{0, 2, 32};
    int hts[2]    = '{0, 1};
    int skips[5]  = '{0, 7, 31, 32, 45};
    int seed;
    pix_ready_i = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(src_ready_o == 0 && pix_valid_o == 0 && done_o == 0, "R1 reset state",
        {29'd0, src_ready_o, pix_valid_o, done_o}, 0);
    rst_ni = 1'b1;
    src_valid_i = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      chk(src_ready_o == 1'b0, "R1 idle ignores source", {31'd0, src_ready_o}, 0);
    end
    src_valid_i = 1'b0;
    seed = 0;
    foreach (deps[a]) foreach (widths[b]) foreach (hts[c]) foreach (skips[d]) begin
      run_frame(widths[b], hts[c], skips[d], deps[a], seed, seed == 10 || seed == 57,
                "R3 R4 R5");
      seed++;
    end
    run_frame(1, 1, 40, 2, 500, 1'b0, "R5 code2");
    run_frame(2, 1, 32767, 3, 501, 1'b0, "R8 max skip");
    run_frame(2, 0, 32767, 0, 502, 1'b0, "R8 max skip");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule